// File: doc/BRIEF.md
# Inline Crypto Keyslot Register Bank

This block is the configuration store behind an inline storage encryption engine. Software programs a small set of keyslots through a 32-bit register bus. Each keyslot holds a 512-bit key area, a control word and an auxiliary configuration word. Software first discovers what the engine offers through read-only capability registers. A global capability word gives the keyslot count minus one, the number of capability entries, and a pointer that places the keyslot array at that pointer times 0x100 bytes. Each capability entry then gives an algorithm code, a key size code and a bitmask of supported data unit sizes.

A keyslot is armed through a fixed write sequence. Software writes the control word with the enable bit clear, then the sixteen key words, then the auxiliary word, and last the control word with the enable bit set. Each keyslot runs a two-state machine. `SLOT_OFF` moves to `SLOT_ON` on a control-word write that has bit 31 set. `SLOT_ON` moves back to `SLOT_OFF` on a control-word write that has bit 31 clear. No other write changes the state. A combinational lookup port serves the encryption datapath. For a slot index it returns the key, the data-unit-size mask, the capability index, the auxiliary word and a valid flag. The flag is high only for an in-range slot in `SLOT_ON`.

Top module: `keyslot_bank`

## Requirements
- R1: After reset every keyslot is in `SLOT_OFF`, its control and auxiliary words read 0, and the lookup reports invalid with all-zero fields for every slot.
- R2: The global capability word at byte address 0x000 reads {8'h00, CFG_PTR[7:0], NUM_CAPS[7:0], NUM_SLOTS-1 [7:0]}, so bits [7:0] hold the slot count minus one and bits [23:16] hold the array pointer.
- R3: Capability entry i (i < NUM_CAPS) reads at byte address 0x010 + 4*i with algorithm code in [7:0], data-unit-size mask in [15:8] (bit k means 512<<k bytes) and key size code in [23:16]. Any other address below the keyslot array reads 0.
- R4: Keyslot s occupies 128 bytes starting at CFG_PTR*0x100 + s*0x80. Key word w (w from 0 to 15) maps to lookup key bits [32w+31:32w], so an XTS key has its first half at key bytes 0..31 and its second half at bytes 32..63. Key words are write-only and read as 0.
- R5: A slot's lookup stays invalid while its key and auxiliary words are written. It becomes valid right after the control word (word 16) is written with bit 31 set. Key and auxiliary writes never change the valid flag.
- R6: Writing word 16 with bit 31 clear makes the lookup invalid right after that write.
- R7: Word 16 reads back {enable, 15'b0, capability index [15:8], data-unit-size mask [7:0]}. Word 17 reads back its full 32-bit value. Words 18 to 31 read 0.
- R8: A lookup with a slot index at or above NUM_SLOTS reports invalid with all-zero fields.
- R9: Writes to one keyslot leave the contents and valid flag of every other keyslot unchanged.
- R10: Programming an all-zero configuration in the normal write order fully clears the slot, so a later enable exposes an all-zero key and auxiliary word.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled, and holds when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lk_slot | input | LK_W (3) | Lookup slot index |
| lk_key | output | 512 | Key of the looked-up slot |
| lk_dus | output | 8 | Data-unit-size mask |
| lk_cap | output | 8 | Capability index |
| lk_aux | output | 32 | Auxiliary word (word 17) |
| lk_valid | output | 1 | Slot armed and in range |

## Verification
A register write is taken at a rising edge. Its effect on the lookup port is visible right after that edge, because the lookup path is combinational from slot state, so the bench drives each write at a falling edge and checks the lookup at the next falling edge. Read data is registered once, so each read strobe is raised for exactly one clock and `bus_rdata` is sampled at the falling edge that follows the capturing edge. Lookup indices are changed at a falling edge and compared a short delay later, well before the next rising edge.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
    localparam int WORD_W       = 32;
    localparam int KEY_WORDS    = 16;
    localparam int KEY_W        = KEY_WORDS * WORD_W;
    localparam int CTRL_WORD    = 16;
    localparam int AUX_WORD     = 17;
    localparam int STRIDE_BYTES = 128;
    localparam int EN_BIT       = 31;
    localparam logic [31:0] CTRL_MASK = 32'h0000_FFFF;

    typedef enum logic {
        SLOT_OFF = 1'b0,
        SLOT_ON  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/keyslot_capregs.sv
module keyslot_capregs #(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_CAPS  = 2,
    parameter int CFG_PTR   = 1,
    parameter int WIDX_W    = 10,
    parameter logic [NUM_CAPS*32-1:0] CAP_TABLE = '0
) (
    input  logic [WIDX_W-1:0] widx,
    output logic              hit,
    output logic [31:0]       data
);
    localparam int CAP_FIRST = 4;
    localparam logic [31:0] GLOBAL_WORD =
        {8'h00, 8'(CFG_PTR), 8'(NUM_CAPS), 8'(NUM_SLOTS - 1)};

    always_comb begin
        hit  = (int'(widx) < CFG_PTR * 64);
        data = '0;
        if (widx == '0) begin
            data = GLOBAL_WORD;
        end
        for (int i = 0; i < NUM_CAPS; i++) begin
            if (int'(widx) == CAP_FIRST + i) begin
                data = CAP_TABLE[i*32 +: 32];
            end
        end
    end
endmodule

// File: rtl/keyslot_slot.sv
module keyslot_slot
    import keyslot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       word_idx,
    input  logic [31:0]      wdata,
    output logic [KEY_W-1:0] key_o,
    output logic [31:0]      ctrl_o,
    output logic [31:0]      aux_o,
    output logic             valid_o
);
    slot_state_e state_q, state_d;
    logic [KEY_W-1:0] key_q;
    logic [15:0]      ctrl_q;
    logic [31:0]      aux_q;
    logic             ctrl_we, key_we, aux_we;

    assign ctrl_we = wr_en && (int'(word_idx) == CTRL_WORD);
    assign aux_we  = wr_en && (int'(word_idx) == AUX_WORD);
    assign key_we  = wr_en && (int'(word_idx) < KEY_WORDS);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_OFF: if (ctrl_we && wdata[EN_BIT])  state_d = SLOT_ON;
            SLOT_ON:  if (ctrl_we && !wdata[EN_BIT]) state_d = SLOT_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_OFF;
        else        state_q <= state_d;
    end

    // Slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            ctrl_q <= '0;
            aux_q  <= '0;
        end else begin
            if (key_we)  key_q[word_idx[3:0]*32 +: 32] <= wdata;
            if (ctrl_we) ctrl_q <= wdata[15:0] & CTRL_MASK[15:0];
            if (aux_we)  aux_q <= wdata;
        end
    end

    // Outputs
    always_comb begin
        valid_o = (state_q == SLOT_ON);
        ctrl_o  = {valid_o, 15'b0, ctrl_q};
        key_o   = key_q;
        aux_o   = aux_q;
    end

    assert_arm_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(ctrl_we && wdata[EN_BIT]));

    assert_key_write_keeps_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we || aux_we) |=> $stable(valid_o));

    assert_disable_drops_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wdata[EN_BIT]) |=> !valid_o);
endmodule

// File: rtl/keyslot_bank.sv
module keyslot_bank
    import keyslot_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_CAPS  = 2,
    parameter int CFG_PTR   = 1,
    parameter int ADDR_W    = 12,
    parameter int LK_W      = 3,
    parameter logic [NUM_CAPS*32-1:0] CAP_TABLE = {32'h0002_0104, 32'h0003_0904}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [LK_W-1:0]   lk_slot,
    output logic [KEY_W-1:0]  lk_key,
    output logic [7:0]        lk_dus,
    output logic [7:0]        lk_cap,
    output logic [31:0]       lk_aux,
    output logic              lk_valid
);
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int SLOT_BASE = CFG_PTR * 256;
    localparam int SLOT_SPAN = NUM_SLOTS * STRIDE_BYTES;
    localparam int SEL_W     = ADDR_W - 7;

    logic [ADDR_W-1:0] rel;
    logic [SEL_W-1:0]  slot_sel;
    logic [4:0]        word_idx;
    logic              slot_hit, cap_hit;
    logic [31:0]       cap_data, rd_next;

    logic [KEY_W-1:0]  key_arr  [NUM_SLOTS];
    logic [31:0]       ctrl_arr [NUM_SLOTS];
    logic [31:0]       aux_arr  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] valid_vec;

    // Address decode
    always_comb begin
        rel      = bus_addr - ADDR_W'(SLOT_BASE);
        slot_sel = rel[ADDR_W-1:7];
        word_idx = rel[6:2];
        slot_hit = (bus_addr[1:0] == 2'b00) &&
                   (int'(bus_addr) >= SLOT_BASE) &&
                   (int'(bus_addr) < SLOT_BASE + SLOT_SPAN);
    end

    keyslot_capregs #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_CAPS(NUM_CAPS), .CFG_PTR(CFG_PTR),
        .WIDX_W(ADDR_W - 2), .CAP_TABLE(CAP_TABLE)
    ) u_caps (
        .widx(bus_addr[ADDR_W-1:2]),
        .hit (cap_hit),
        .data(cap_data)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic sel;
        assign sel = bus_wr && slot_hit && (int'(slot_sel) == s);
        keyslot_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel),
            .word_idx(word_idx),
            .wdata   (bus_wdata),
            .key_o   (key_arr[s]),
            .ctrl_o  (ctrl_arr[s]),
            .aux_o   (aux_arr[s]),
            .valid_o (valid_vec[s])
        );
    end

    // Read path
    always_comb begin
        rd_next = '0;
        if (slot_hit) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (int'(slot_sel) == s) begin
                    if (int'(word_idx) == CTRL_WORD)     rd_next = ctrl_arr[s];
                    else if (int'(word_idx) == AUX_WORD) rd_next = aux_arr[s];
                end
            end
        end else if (cap_hit && bus_addr[1:0] == 2'b00) begin
            rd_next = cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // Lookup path
    always_comb begin
        lk_key   = '0;
        lk_dus   = '0;
        lk_cap   = '0;
        lk_aux   = '0;
        lk_valid = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (int'(lk_slot) == s && valid_vec[s]) begin
                lk_valid = 1'b1;
                lk_key   = key_arr[s];
                lk_dus   = ctrl_arr[s][7:0];
                lk_cap   = ctrl_arr[s][15:8];
                lk_aux   = aux_arr[s];
            end
        end
    end

    assert_key_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && slot_hit && int'(word_idx) < KEY_WORDS) |=> (bus_rdata == '0));

    assert_reserved_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && slot_hit && int'(word_idx) > AUX_WORD) |=> (bus_rdata == '0));

    assert_oob_lookup_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_slot) >= NUM_SLOTS) |-> (!lk_valid && lk_key == '0));

    assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/keyslot_bank_tb.sv
module keyslot_bank_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [2:0]   lk_slot = '0;
    logic [511:0] lk_key;
    logic [7:0]   lk_dus, lk_cap;
    logic [31:0]  lk_aux;
    logic         lk_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    keyslot_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lk_slot(lk_slot), .lk_key(lk_key), .lk_dus(lk_dus), .lk_cap(lk_cap),
        .lk_aux(lk_aux), .lk_valid(lk_valid)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic logic [11:0] sa(input int s, input int w);
        return 12'(256 + s * 128 + w * 4);
    endfunction

    function automatic logic [31:0] kw(input int s, input int w, input int seed);
        return {8'(seed), 8'(s), 8'hC0, 8'(w)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic look(input int s);
        lk_slot = 3'(s);
        #1;
    endtask

    task automatic load_keys(input int s, input int seed);
        for (int w = 0; w < 16; w++) wr(sa(s, w), (seed < 0) ? 32'h0 : kw(s, w, seed));
    endtask

    task automatic check_key(input string tag, input int s, input int seed);
        for (int w = 0; w < 16; w++)
            check(tag, lk_key[w*32 +: 32], (seed < 0) ? 32'h0 : kw(s, w, seed));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int s = 0; s < 4; s++) begin
            rd(sa(s, 16), d); check("R1 ctrl after reset", d, 32'h0);
            rd(sa(s, 17), d); check("R1 aux after reset", d, 32'h0);
            look(s);
            check("R1 lookup valid after reset", 32'(lk_valid), 32'h0);
            check("R1 lookup aux after reset", lk_aux, 32'h0);
        end
    endtask

    task automatic t_caps();
        logic [31:0] d;
        rd(12'h000, d); check("R2 global capability", d, 32'h0001_0203);
        rd(12'h010, d); check("R3 capability 0", d, 32'h0003_0904);
        rd(12'h014, d); check("R3 capability 1", d, 32'h0002_0104);
        rd(12'h018, d); check("R3 past last capability", d, 32'h0);
        rd(12'h004, d); check("R3 unused capability address", d, 32'h0);
    endtask

    task automatic t_program();
        logic [31:0] d;
        wr(sa(1, 16), 32'h0);
        load_keys(1, 8'h5A);
        look(1); check("R5 invalid after key words", 32'(lk_valid), 32'h0);
        wr(sa(1, 17), 32'hDEAD_0017);
        look(1); check("R5 invalid after aux word", 32'(lk_valid), 32'h0);
        wr(sa(1, 16), 32'h8000_0008);
        look(1);
        check("R5 valid after enable", 32'(lk_valid), 32'h1);
        check("R5 lookup dus", 32'(lk_dus), 32'h08);
        check("R5 lookup cap index", 32'(lk_cap), 32'h00);
        check("R5 lookup aux", lk_aux, 32'hDEAD_0017);
        check_key("R4 key words in order", 1, 8'h5A);
        check("R4 xts first half low word", lk_key[31:0], kw(1, 0, 8'h5A));
        check("R4 xts second half at byte 32", lk_key[287:256], kw(1, 8, 8'h5A));
        rd(sa(1, 3), d);  check("R4 key word reads zero", d, 32'h0);
        rd(sa(1, 16), d); check("R7 ctrl readback", d, 32'h8000_0008);
        rd(sa(1, 17), d); check("R7 aux readback", d, 32'hDEAD_0017);
        wr(sa(1, 20), 32'hFFFF_FFFF);
        rd(sa(1, 20), d); check("R7 reserved word reads zero", d, 32'h0);
        wr(sa(1, 5), 32'h1234_5678);
        look(1); check("R5 key write keeps valid", 32'(lk_valid), 32'h1);
        wr(sa(1, 5), kw(1, 5, 8'h5A));
    endtask

    task automatic t_isolation();
        wr(sa(2, 16), 32'h0);
        load_keys(2, 8'h33);
        wr(sa(2, 17), 32'h0000_0222);
        wr(sa(2, 16), 32'h8000_0101);
        look(2);
        check("R9 slot2 valid", 32'(lk_valid), 32'h1);
        check("R9 slot2 cap index", 32'(lk_cap), 32'h01);
        check_key("R9 slot2 key", 2, 8'h33);
        look(1);
        check("R9 slot1 still valid", 32'(lk_valid), 32'h1);
        check("R9 slot1 aux unchanged", lk_aux, 32'hDEAD_0017);
        check_key("R9 slot1 key unchanged", 1, 8'h5A);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(sa(1, 16), 32'h0);
        look(1); check("R6 invalid after disable", 32'(lk_valid), 32'h0);
        load_keys(1, -1);
        wr(sa(1, 17), 32'h0);
        wr(sa(1, 16), 32'h0);
        rd(sa(1, 16), d); check("R10 ctrl cleared", d, 32'h0);
        rd(sa(1, 17), d); check("R10 aux cleared", d, 32'h0);
        wr(sa(1, 16), 32'h8000_0001);
        look(1);
        check("R10 re-enabled valid", 32'(lk_valid), 32'h1);
        check("R10 aux zero", lk_aux, 32'h0);
        check_key("R10 key zero", 1, -1);
        look(2); check("R9 slot2 unaffected by clear", 32'(lk_valid), 32'h1);
    endtask

    task automatic t_oob();
        logic [31:0] d;
        wr(12'h300, 32'h8000_00FF);
        for (int s = 4; s < 8; s++) begin
            look(s);
            check("R8 out-of-range invalid", 32'(lk_valid), 32'h0);
            check("R8 out-of-range key zero", lk_key[31:0], 32'h0);
        end
        look(3); check("R8 write past array leaves slot3 off", 32'(lk_valid), 32'h0);
        rd(sa(2, 17), d); check("R11 read value", d, 32'h0000_0222);
        @(negedge clk); @(negedge clk);
        check("R11 rdata holds without read", bus_rdata, 32'h0000_0222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_caps();
        t_program();
        t_isolation();
        t_clear();
        t_oob();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule